// File: doc/BRIEF.md
# Processor Clock Burst-Width Controller

This block rations the processor clock to save power. It drives a per-cycle clock-enable that a downstream clock gate uses. A control byte written over a simple bus holds an enable flag and a five-bit width. While the flag is clear, the enable output stays high on every cycle, so the processor runs continuously.

While the flag is set, time is divided into frames of 31 cycles, called slots. The processor clock is passed for the first WIDTH slots of each frame and held off for the rest. A width of 31 therefore gives an uninterrupted clock. A width of zero holds the clock off entirely, which is the doze state. After reset the flag is clear and the width is 31.

A wake-up input overrides the rationing in the same cycle it is asserted. It also clears the flag in hardware, so the clock stays continuous until software sets the flag again. Software can read the control byte back at any time. A two-bit mode output reports whether the block is in the normal, burst or doze state.

Top module: `clk_ration_ctrl`

## Requirements
- R1: After reset, `rd_data_o` reads 0x1F (flag clear, width 31), `mode_o` is 0 (normal) and `cpu_clk_en_o` is high.
- R2: While the enable flag (bit 7) is clear, `cpu_clk_en_o` is high on every cycle.
- R3: `rd_data_o` shows the flag in bit 7 and the width in bits 4:0. Bits 6:5 always read zero. A write with `wr_en_i` high takes effect on the next cycle.
- R4: While the flag is set, a slot counter starts at 0 on the first enabled cycle and runs 0 to 30, then wraps to 0. `cpu_clk_en_o` is high exactly when the slot is below the width, so each 31-cycle frame passes exactly WIDTH cycles.
- R5: With the flag set and a width of 31, `cpu_clk_en_o` stays high on every cycle.
- R6: With the flag set and a width of 0, `cpu_clk_en_o` stays low until a wake-up or a reset (doze).
- R7: When `wake_i` is high, `cpu_clk_en_o` is high in that same cycle. From the next cycle the flag reads clear and the width is kept.
- R8: When a write and a wake-up arrive in the same cycle, the written width is stored and the flag is cleared, whatever the value written to bit 7.
- R9: `mode_o` is 0 while the flag is clear, 1 while the flag is set with a nonzero width, and 2 while the flag is set with a zero width. The value 3 never appears.
- R10: Rewriting the control byte while the flag stays set does not restart the slot counter. The new width applies from the current slot onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control byte |
| wr_data_i | input | 8 | Control byte: bit 7 flag, bits 4:0 width |
| wake_i | input | 1 | Wake-up event |
| rd_data_o | output | 8 | Control byte read-back |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| mode_o | output | 2 | 0 normal, 1 burst, 2 doze |

## Verification
The hardest situations to reach are the wake-up pulse that coincides with a write, and a rewrite of the width in the middle of a frame while the flag stays set. Both depend on exact cycle alignment against the running slot counter. Random traffic with frequent writes and occasional wake-ups reaches them many times, and a bench model of the flag, the width and the slot counter is compared every cycle. Directed sequences add a full doze hold, a count of the enabled cycles in a 10-of-31 frame, and a coincident write and wake-up.

// File: rtl/clk_ration_pkg.sv
package clk_ration_pkg;
  parameter int unsigned WIDTH_BITS = 5;
  parameter int unsigned DATA_W     = 8;
  parameter int unsigned FLAG_BIT   = 7;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_BURST  = 2'd1,
    MODE_DOZE   = 2'd2
  } ration_mode_e;
endpackage

// File: rtl/ration_ctrl_reg.sv
module ration_ctrl_reg
  import clk_ration_pkg::*;
#(
  parameter int unsigned WB = WIDTH_BITS,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned FB = FLAG_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wake_i,
  output logic          flag_o,
  output logic [WB-1:0] width_o,
  output logic [DW-1:0] rd_data_o
);
  localparam logic [WB-1:0] WIDTH_RST = {WB{1'b1}};

  logic          flag_q, flag_d;
  logic [WB-1:0] width_q, width_d;

  always_comb begin
    flag_d  = flag_q;
    width_d = width_q;
    if (wr_en_i) begin
      flag_d  = wr_data_i[FB];
      width_d = wr_data_i[WB-1:0];
    end
    if (wake_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      width_q <= WIDTH_RST;
    end else begin
      flag_q  <= flag_d;
      width_q <= width_d;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < DW; gi++) begin : g_rd
      if (gi == FB) begin : g_flag
        assign rd_data_o[gi] = flag_q;
      end else if (gi < WB) begin : g_width
        assign rd_data_o[gi] = width_q[gi];
      end else begin : g_zero
        assign rd_data_o[gi] = 1'b0;
      end
    end
  endgenerate

  assign flag_o  = flag_q;
  assign width_o = width_q;

  p_wake_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !flag_q);
  p_width_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(width_q));
  p_flag_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !wake_i) |=> $stable(flag_q));
endmodule

// File: rtl/ration_slot_counter.sv
module ration_slot_counter
  import clk_ration_pkg::*;
#(
  parameter int unsigned WB = WIDTH_BITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic [WB-1:0] slot_o
);
  localparam int unsigned   FRAME    = (1 << WB) - 1;
  localparam logic [WB-1:0] LAST     = WB'(FRAME - 1);

  logic [WB-1:0] slot_q, slot_d;
  logic          slot_ce;

  assign slot_ce = run_i || (slot_q != '0);

  always_comb begin
    if (!run_i)              slot_d = '0;
    else if (slot_q == LAST) slot_d = '0;
    else                     slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      slot_q <= '0;
    else if (slot_ce) slot_q <= slot_d;
  end

  assign slot_o = slot_q;

  p_slot_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= LAST);
  p_slot_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && slot_q == LAST) |=> slot_q == '0);
  p_slot_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> slot_q == '0);
endmodule

// File: rtl/ration_gate.sv
module ration_gate
  import clk_ration_pkg::*;
#(
  parameter int unsigned WB = WIDTH_BITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flag_i,
  input  logic [WB-1:0] width_i,
  input  logic [WB-1:0] slot_i,
  input  logic          wake_i,
  output logic          clk_en_o,
  output logic [1:0]    mode_o
);
  ration_mode_e mode;

  always_comb begin
    if (!flag_i)              mode = MODE_NORMAL;
    else if (width_i == '0)   mode = MODE_DOZE;
    else                      mode = MODE_BURST;
  end

  assign clk_en_o = !flag_i || wake_i || (slot_i < width_i);
  assign mode_o   = mode;

  p_normal_runs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_i |-> clk_en_o);
  p_doze_stops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && width_i == '0 && !wake_i) |-> !clk_en_o);
  p_wake_runs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |-> clk_en_o);
  p_mode_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);
endmodule

// File: rtl/clk_ration_ctrl.sv
module clk_ration_ctrl
  import clk_ration_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wake_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              cpu_clk_en_o,
  output logic [1:0]        mode_o
);
  logic                  flag;
  logic [WIDTH_BITS-1:0] width;
  logic [WIDTH_BITS-1:0] slot;

  ration_ctrl_reg #(.WB(WIDTH_BITS), .DW(DATA_W), .FB(FLAG_BIT)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .wake_i    (wake_i),
    .flag_o    (flag),
    .width_o   (width),
    .rd_data_o (rd_data_o)
  );

  ration_slot_counter #(.WB(WIDTH_BITS)) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (flag),
    .slot_o (slot)
  );

  ration_gate #(.WB(WIDTH_BITS)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flag_i   (flag),
    .width_i  (width),
    .slot_i   (slot),
    .wake_i   (wake_i),
    .clk_en_o (cpu_clk_en_o),
    .mode_o   (mode_o)
  );
endmodule

// File: tb/sim_clk_ration_ctrl.sv
module sim_clk_ration_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       wake = 1'b0;
  logic [7:0] rd_data;
  logic       clk_en;
  logic [1:0] mode;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic       m_flag;
  logic [4:0] m_width;
  logic [4:0] m_slot;

  always #2 clk = ~clk;

  clk_ration_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wdata),
    .wake_i(wake), .rd_data_o(rd_data), .cpu_clk_en_o(clk_en), .mode_o(mode)
  );

  function automatic logic exp_en(logic f, logic [4:0] w, logic [4:0] s, logic wk);
    return !f || wk || (s < w);
  endfunction

  function automatic logic [1:0] exp_mode(logic f, logic [4:0] w);
    if (!f) return 2'd0;
    if (w == 5'd0) return 2'd2;
    return 2'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] d, input logic wk);
    logic e;
    string r;
    wr_en = wr; wdata = d; wake = wk;
    #1;
    e = exp_en(m_flag, m_width, m_slot, wk);
    if (wk && m_flag)          r = "R7";
    else if (!m_flag)          r = "R2";
    else if (m_width == 5'd0)  r = "R6";
    else if (m_width == 5'd31) r = "R5";
    else                       r = "R4";
    chk(clk_en == e, r, clk_en, e);
    chk(mode == exp_mode(m_flag, m_width), "R9", mode, exp_mode(m_flag, m_width));
    chk(rd_data == {m_flag, 2'b00, m_width}, "R3", rd_data, {m_flag, 2'b00, m_width});
    @(posedge clk);
    // R10: slot advances whenever flag stays set, independent of writes
    m_slot = m_flag ? ((m_slot == 5'd30) ? 5'd0 : m_slot + 5'd1) : 5'd0;
    if (wr) begin m_flag = d[7]; m_width = d[4:0]; end
    if (wk) m_flag = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int hi;
    void'($urandom(32'h5EED_1234));
    m_flag = 1'b0; m_width = 5'd31; m_slot = 5'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rd_data == 8'h1F, "R1", rd_data, 8'h1F);
    chk(mode == 2'd0, "R1", mode, 0);
    chk(clk_en == 1'b1, "R1", clk_en, 1);
    @(negedge clk);

    repeat (40) step(1'b0, 8'h00, 1'b0);              // R2
    step(1'b1, 8'h9F, 1'b0);                          // R5 full duty
    repeat (70) step(1'b0, 8'h00, 1'b0);
    step(1'b1, 8'h8A, 1'b0);                          // R4 width 10
    hi = 0;
    for (int i = 0; i < 31; i++) begin
      hi += (clk_en === 1'b1) ? 1 : 0;
      step(1'b0, 8'h00, 1'b0);
    end
    chk(hi == 10, "R4", hi, 10);
    step(1'b1, 8'h83, 1'b0);                          // R10 mid-frame rewrite
    repeat (40) step(1'b0, 8'h00, 1'b0);
    step(1'b1, 8'hE0, 1'b0);                          // R6 doze, R3 bits 6:5
    hi = 0;
    for (int i = 0; i < 100; i++) begin
      hi += (clk_en === 1'b1) ? 1 : 0;
      step(1'b0, 8'h00, 1'b0);
    end
    chk(hi == 0, "R6", hi, 0);
    step(1'b0, 8'h00, 1'b1);                          // R7 wake from doze
    chk(rd_data == 8'h00, "R7", rd_data, 8'h00);
    step(1'b1, 8'h8C, 1'b0);
    step(1'b1, 8'h85, 1'b1);                          // R8 write with wake
    chk(rd_data == 8'h05, "R8", rd_data, 8'h05);
    chk(mode == 2'd0, "R8", mode, 0);

    for (int i = 0; i < 4000; i++) begin
      logic wr, wk;
      logic [7:0] d;
      wr = ($urandom_range(0, 9) == 0);
      wk = ($urandom_range(0, 39) == 0);
      d  = 8'($urandom);
      if ($urandom_range(0, 1) == 0) d[7] = 1'b1;
      step(wr, d, wk);
    end

    rst_n = 1'b0;
    #1;
    chk(rd_data == 8'h1F, "R1", rd_data, 8'h1F);
    chk(clk_en == 1'b1, "R1", clk_en, 1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule